// File: doc/BRIEF.md
# Reset Source and Startup Sequencer

This block merges three reset requests into a single held CPU reset and decides when the CPU may start running. The requests are a power-good level, a watchdog expiry pulse and a USB bus reset pulse. A low power-good level clears the whole block asynchronously. On the first clock after power-good rises, the block reads a strap input and the two USB data lines. It then takes one of two paths. It may park in a suspend state until the bus shows activity. Otherwise it starts a release delay, measured in ticks of a prescaled time base, and frees the CPU when the delay ends.

Each source leaves a mark in a three-bit sticky cause register. Software reads the marks and clears them through a write port with write-zero-to-clear semantics. The delay length is picked from the strap and the stored power-on mark. A strap that is high always gives the short delay. A strap that is low with the power-on mark still set gives the long delay. Every other case gives the short delay. A USB bus reset only sets its mark and pulses a device-address clear. It never stops a running CPU.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `pwr_ok_i` is low, `cpu_rst_n_o`=0, `suspend_o`=0, `addr_clr_o`=1 and `cause_o`=3'b001. Bit 0 is power-on, bit 1 is USB bus reset and bit 2 is watchdog.
- R2: On the first clock after power-good rises, the block enters suspend (`suspend_o`=1, CPU held) if the strap is high and the lines are idle (J: `dm_i`=1, `dp_i`=0). In every other case it goes straight into the release delay.
- R3: Suspend ends when the lines show K (`dp_i`=1, `dm_i`=0), when they show SE0 (both 0), or when a `bus_rst_i` pulse arrives. The block then enters the release delay, with its length picked by the rule in R5 at that moment.
- R4: While suspended, J and SE1 (both 1) leave the block in suspend with the CPU held.
- R5: The delay length is picked when the delay starts. It is SHORT_TICKS if the strap is high. It is LONG_TICKS if the strap is low and `cause_o[0]` is set. It is SHORT_TICKS if the strap is low and `cause_o[0]` is clear.
- R6: During the delay, only cycles with `tick_i`=1 count. `cpu_rst_n_o` rises one clock after the clock that samples the last tick of the selected length, and not before.
- R7: A `wdt_trip_i` pulse in any state sets `cause_o[2]`, drives `cpu_rst_n_o` low on the next clock, and restarts the delay count from zero.
- R8: A `bus_rst_i` pulse sets `cause_o[1]` and drives `addr_clr_o` high for exactly one cycle. It leaves a running CPU running.
- R9: A write with `wr_en_i`=1 clears each cause bit whose data bit is 0: bit 4 maps to power-on, bit 5 to bus reset and bit 6 to watchdog. A data bit of 1 leaves its cause bit unchanged. A source event in the same cycle wins over the clear.
- R10: A watchdog or bus reset event never clears a cause bit that it does not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| pwr_ok_i | input | 1 | Power-good level, low clears the block asynchronously |
| wdt_trip_i | input | 1 | Watchdog expiry pulse |
| bus_rst_i | input | 1 | USB bus reset detected pulse |
| strap_i | input | 1 | Startup strap pin |
| dp_i | input | 1 | USB D+ line state |
| dm_i | input | 1 | USB D- line state |
| tick_i | input | 1 | Prescaled time-base tick |
| wr_en_i | input | 1 | Cause register write strobe |
| wr_data_i | input | 8 | Cause register write data (bits 6:4 used) |
| cpu_rst_n_o | output | 1 | CPU reset, active low |
| cause_o | output | 3 | Sticky cause bits {watchdog, bus reset, power-on} |
| suspend_o | output | 1 | Block waits in suspend for bus activity |
| addr_clr_o | output | 1 | Clears the USB device address |

## Verification
The bench goes after the three branches of the delay choice, including a power-on mark cleared while suspended. A design that tested the strap and the mark in the wrong order would free the CPU many ticks early or late. Ticks arrive with random gaps, and release is checked against the exact tick count. This catches an off-by-one terminal count and a counter that runs on every cycle. A watchdog pulse in the middle of a delay must restart the count, not resume it. A write that clears bits in the same cycle as a watchdog event must keep the watchdog mark. A bus reset must leave a running CPU alone and must not wipe the other marks.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_SUSP = 2'd1,
        ST_DLY  = 2'd2,
        ST_RUN  = 2'd3
    } rsq_state_e;

    localparam int CAUSE_W = 3;
    localparam int C_POR   = 0;
    localparam int C_USB   = 1;
    localparam int C_WDR   = 2;
    localparam int WR_W    = 8;
    localparam int WR_BASE = 4;

    typedef struct packed {
        rsq_state_e state;
        logic       usb_pulse;
    } seq_regs_t;

endpackage

// File: rtl/rsq_line_dec.sv
module rsq_line_dec #(
    parameter bit IDLE_DM_HIGH = 1'b1
) (
    input  logic dp_i,
    input  logic dm_i,
    output logic idle_o,
    output logic wake_o
);
    logic se0;
    logic j_st;
    logic k_st;

    assign se0 = ~dp_i & ~dm_i;

    generate
        if (IDLE_DM_HIGH) begin : g_dm_idle
            assign j_st = dm_i & ~dp_i;
            assign k_st = dp_i & ~dm_i;
        end else begin : g_dp_idle
            assign j_st = dp_i & ~dm_i;
            assign k_st = dm_i & ~dp_i;
        end
    endgenerate

    assign idle_o = j_st;
    assign wake_o = k_st | se0;
endmodule

// File: rtl/rsq_flags.sv
module rsq_flags #(
    parameter int                  N       = 3,
    parameter logic [N-1:0]        RST_VAL = 3'b001
) (
    input  logic         clk_i,
    input  logic         pwr_ok_i,
    input  logic [N-1:0] set_i,
    input  logic         wr_en_i,
    input  logic [N-1:0] wr_bits_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flags_d, flags_q;
    logic [N-1:0] clr;

    always_comb begin
        clr     = wr_en_i ? ~wr_bits_i : '0;
        flags_d = (flags_q & ~clr) | set_i;
    end

    always_ff @(posedge clk_i or negedge pwr_ok_i) begin
        if (!pwr_ok_i) flags_q <= RST_VAL;
        else           flags_q <= flags_d;
    end

    assign flags_o = flags_q;
endmodule

// File: rtl/rsq_timer.sv
module rsq_timer #(
    parameter int SHORT_TICKS = 128,
    parameter int LONG_TICKS  = 96000
) (
    input  logic clk_i,
    input  logic pwr_ok_i,
    input  logic start_i,
    input  logic long_i,
    input  logic run_i,
    input  logic tick_i,
    output logic expire_o
);
    localparam int MAXT  = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int CNT_W = $clog2(MAXT + 1);
    localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_TICKS - 1);
    localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_TICKS - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             long_sel;
    } tmr_regs_t;

    tmr_regs_t        t_d, t_q;
    logic [CNT_W-1:0] last;

    always_comb begin
        t_d      = t_q;
        expire_o = 1'b0;
        last     = t_q.long_sel ? LONG_LAST : SHORT_LAST;
        if (start_i) begin
            t_d.cnt      = '0;
            t_d.long_sel = long_i;
        end else if (run_i && tick_i) begin
            if (t_q.cnt == last) expire_o = 1'b1;
            else                 t_d.cnt  = t_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge pwr_ok_i) begin
        if (!pwr_ok_i) t_q <= '0;
        else           t_q <= t_d;
    end
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rsq_pkg::*;
#(
    parameter int SHORT_TICKS  = 128,
    parameter int LONG_TICKS   = 96000,
    parameter bit IDLE_DM_HIGH = 1'b1
) (
    input  logic               clk_i,
    input  logic               pwr_ok_i,
    input  logic               wdt_trip_i,
    input  logic               bus_rst_i,
    input  logic               strap_i,
    input  logic               dp_i,
    input  logic               dm_i,
    input  logic               tick_i,
    input  logic               wr_en_i,
    input  logic [WR_W-1:0]    wr_data_i,
    output logic               cpu_rst_n_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               suspend_o,
    output logic               addr_clr_o
);
    seq_regs_t          s_d, s_q;
    logic               line_idle, line_wake;
    logic               start, long_sel, expire, run;
    logic [CAUSE_W-1:0] cause_set;
    logic [CAUSE_W-1:0] wr_bits;
    logic               wr_unused;

    assign wr_bits   = wr_data_i[WR_BASE +: CAUSE_W];
    assign wr_unused = ^{wr_data_i[WR_W-1:WR_BASE+CAUSE_W], wr_data_i[WR_BASE-1:0]};

    rsq_line_dec #(.IDLE_DM_HIGH(IDLE_DM_HIGH)) u_line (
        .dp_i   (dp_i),
        .dm_i   (dm_i),
        .idle_o (line_idle),
        .wake_o (line_wake)
    );

    always_comb begin
        cause_set        = '0;
        cause_set[C_USB] = bus_rst_i;
        cause_set[C_WDR] = wdt_trip_i;
    end

    rsq_flags #(.N(CAUSE_W), .RST_VAL(3'b001)) u_flags (
        .clk_i     (clk_i),
        .pwr_ok_i  (pwr_ok_i),
        .set_i     (cause_set),
        .wr_en_i   (wr_en_i),
        .wr_bits_i (wr_bits),
        .flags_o   (cause_o)
    );

    rsq_timer #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_timer (
        .clk_i    (clk_i),
        .pwr_ok_i (pwr_ok_i),
        .start_i  (start),
        .long_i   (long_sel),
        .run_i    (run),
        .tick_i   (tick_i),
        .expire_o (expire)
    );

    always_comb begin
        s_d           = s_q;
        s_d.usb_pulse = bus_rst_i;
        start         = 1'b0;
        long_sel      = ~strap_i & cause_o[C_POR];
        run           = (s_q.state == ST_DLY);
        unique case (s_q.state)
            ST_HOLD: begin
                if (strap_i && line_idle) begin
                    s_d.state = ST_SUSP;
                end else begin
                    s_d.state = ST_DLY;
                    start     = 1'b1;
                end
            end
            ST_SUSP: begin
                if (line_wake || bus_rst_i) begin
                    s_d.state = ST_DLY;
                    start     = 1'b1;
                end
            end
            ST_DLY: begin
                if (expire) s_d.state = ST_RUN;
            end
            default: s_d.state = ST_RUN;
        endcase
        if (wdt_trip_i) begin
            s_d.state = ST_DLY;
            start     = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge pwr_ok_i) begin
        if (!pwr_ok_i) s_q <= '{state: ST_HOLD, usb_pulse: 1'b0};
        else           s_q <= s_d;
    end

    assign cpu_rst_n_o = (s_q.state == ST_RUN);
    assign suspend_o   = (s_q.state == ST_SUSP);
    assign addr_clr_o  = (s_q.state != ST_RUN) | s_q.usb_pulse;
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk (
    input logic       clk_i,
    input logic       pwr_ok_i,
    input logic       wdt_trip_i,
    input logic       bus_rst_i,
    input logic       dp_i,
    input logic       dm_i,
    input logic       tick_i,
    input logic       wr_en_i,
    input logic [7:0] wr_data_i,
    input logic       cpu_rst_n_o,
    input logic [2:0] cause_o,
    input logic       suspend_o,
    input logic       addr_clr_o
);
    // R6
    release_on_tick_chk: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        $rose(cpu_rst_n_o) |-> $past(tick_i));

    // R4
    suspend_on_idle_chk: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        (suspend_o && dm_i && !dp_i && !bus_rst_i && !wdt_trip_i) |=> suspend_o);

    // R7
    wdt_holds_cpu_chk: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        wdt_trip_i |=> (!cpu_rst_n_o && cause_o[2]));

    // R8
    busrst_keeps_run_chk: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        (bus_rst_i && cpu_rst_n_o && !wdt_trip_i) |=> (cpu_rst_n_o && cause_o[1] && addr_clr_o));

    // R9
    clear_por_chk: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        (wr_en_i && !wr_data_i[4]) |=> !cause_o[0]);

    // R10
    wdr_sticky_chk: assert property (@(posedge clk_i) disable iff (!pwr_ok_i)
        (cause_o[2] && !(wr_en_i && !wr_data_i[6])) |=> cause_o[2]);
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk u_chk (
    .clk_i       (clk_i),
    .pwr_ok_i    (pwr_ok_i),
    .wdt_trip_i  (wdt_trip_i),
    .bus_rst_i   (bus_rst_i),
    .dp_i        (dp_i),
    .dm_i        (dm_i),
    .tick_i      (tick_i),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .cpu_rst_n_o (cpu_rst_n_o),
    .cause_o     (cause_o),
    .suspend_o   (suspend_o),
    .addr_clr_o  (addr_clr_o)
);

// File: tb/rst_seq_ctrl_bench.sv
`timescale 1ns/1ps
module rst_seq_ctrl_bench;
    localparam int SHORT = 6;
    localparam int LONG  = 25;

    logic       clk = 1'b0;
    logic       pwr_ok = 1'b0, wdt = 1'b0, bus_rst = 1'b0, strap = 1'b0;
    logic       dp = 1'b0, dm = 1'b1, tick = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_data = 8'hff;
    logic       cpu_rst_n, suspend, addr_clr;
    logic [2:0] cause;
    int         total = 0, bad = 0;
    logic [2:0] ef;

    always #2.5 clk = ~clk;

    rst_seq_ctrl #(.SHORT_TICKS(SHORT), .LONG_TICKS(LONG)) u_rst_seq_ctrl (
        .clk_i(clk), .pwr_ok_i(pwr_ok), .wdt_trip_i(wdt), .bus_rst_i(bus_rst),
        .strap_i(strap), .dp_i(dp), .dm_i(dm), .tick_i(tick), .wr_en_i(wr_en),
        .wr_data_i(wr_data), .cpu_rst_n_o(cpu_rst_n), .cause_o(cause),
        .suspend_o(suspend), .addr_clr_o(addr_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int sel_lim(input bit s, input bit por);
        return (!s && por) ? LONG : SHORT;
    endfunction

    // R6: release exactly after lim ticks counted in delay
    task automatic run_ticks(input int lim, input int n, input string req);
        int cnt = 0;
        while (cnt < n) begin
            tick = ($urandom_range(0, 2) != 0);
            step;
            if (tick) cnt++;
            tick = 1'b0;
            chk({req, " R6 release"}, int'(cpu_rst_n), int'(cnt >= lim));
        end
    endtask

    task automatic power_on(input bit s, input bit p, input bit m);
        pwr_ok = 1'b0; strap = s; dp = p; dm = m;
        step; step;
        chk("R1 cpu reset", int'(cpu_rst_n), 0);
        chk("R1 suspend", int'(suspend), 0);
        chk("R1 addr clear", int'(addr_clr), 1);
        chk("R1 cause", int'(cause), 1);
        pwr_ok = 1'b1;
        step;
        ef = 3'b001;
    endtask

    task automatic pulse_wdt;
        wdt = 1'b1; step; wdt = 1'b0;
    endtask

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d; step; wr_en = 1'b0; wr_data = 8'hff;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        @(negedge clk);
        // R5: strap low, power-on mark set -> long
        power_on(1'b0, 1'b0, 1'b1);
        chk("R2 no suspend strap low", int'(suspend), 0);
        run_ticks(LONG, LONG, "R5 long");
        chk("R10 cause after start", int'(cause), int'(ef));

        // R9 write semantics
        wr(8'h70);
        chk("R9 write ones keep", int'(cause), 1);
        wr(8'h60);
        ef = 3'b000;
        chk("R9 clear power-on", int'(cause), int'(ef));

        // R7 watchdog and restart
        pulse_wdt;
        ef = 3'b100;
        chk("R7 cpu held", int'(cpu_rst_n), 0);
        chk("R7 cause", int'(cause), int'(ef));
        run_ticks(SHORT, 3, "R7 partial");
        pulse_wdt;
        run_ticks(SHORT, SHORT, "R7 restart");

        // R8 bus reset while running
        bus_rst = 1'b1; step; bus_rst = 1'b0;
        chk("R8 cpu keeps running", int'(cpu_rst_n), 1);
        chk("R8 addr clear pulse", int'(addr_clr), 1);
        chk("R10 cause keeps wdr", int'(cause), 6);
        step;
        chk("R8 addr clear one cycle", int'(addr_clr), 0);

        // R9 set wins over clear
        wr_en = 1'b1; wr_data = 8'h00; wdt = 1'b1; step;
        wr_en = 1'b0; wr_data = 8'hff; wdt = 1'b0;
        chk("R9 set wins", int'(cause), 4);
        run_ticks(SHORT, SHORT, "R5 short por clear");

        // random rounds of watchdog with random strap and mark
        power_on(1'b0, 1'b0, 1'b1);
        run_ticks(LONG, LONG, "R5 long");
        for (int r = 0; r < 8; r++) begin
            bit s;
            s = 1'($urandom_range(0, 1));
            if ($urandom_range(0, 1) == 1) begin
                wr(8'h60);
                ef[0] = 1'b0;
            end
            strap = s;
            pulse_wdt;
            ef[2] = 1'b1;
            chk("R10 cause random", int'(cause), int'(ef));
            run_ticks(sel_lim(s, ef[0]), sel_lim(s, ef[0]), "R5 random");
        end
        strap = 1'b0;

        // R2/R4/R3 suspend with K wake
        power_on(1'b1, 1'b0, 1'b1);
        chk("R2 suspend", int'(suspend), 1);
        chk("R2 cpu held", int'(cpu_rst_n), 0);
        for (int i = 0; i < 8; i++) begin
            dp = 1'($urandom_range(0, 1)); dm = 1'b1;
            tick = 1'($urandom_range(0, 1));
            step;
            tick = 1'b0;
            chk("R4 stay suspended", int'(suspend), 1);
            chk("R4 cpu held", int'(cpu_rst_n), 0);
        end
        dp = 1'b1; dm = 1'b0; step;
        chk("R3 wake on K", int'(suspend), 0);
        run_ticks(SHORT, SHORT, "R3 short strap high");
        dp = 1'b0; dm = 1'b1;

        // R2 strap high but SE0 -> direct short delay
        power_on(1'b1, 1'b0, 1'b0);
        chk("R2 no suspend when busy", int'(suspend), 0);
        run_ticks(SHORT, SHORT, "R5 strap high short");
        dp = 1'b0; dm = 1'b1;

        // R3 SE0 wake with strap low and mark set -> long
        power_on(1'b1, 1'b0, 1'b1);
        strap = 1'b0; step;
        chk("R4 strap change stays", int'(suspend), 1);
        dp = 1'b0; dm = 1'b0; step;
        chk("R3 wake on SE0", int'(suspend), 0);
        run_ticks(LONG, LONG, "R3 long after wake");
        dp = 1'b0; dm = 1'b1;

        // R3 bus reset wake, mark cleared -> short
        power_on(1'b1, 1'b0, 1'b1);
        wr(8'h60);
        strap = 1'b0;
        bus_rst = 1'b1; step; bus_rst = 1'b0;
        chk("R3 wake on bus reset", int'(suspend), 0);
        chk("R8 cause bus reset", int'(cause), 2);
        run_ticks(SHORT, SHORT, "R5 mark clear short");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule